// File: doc/BRIEF.md
# Sleep Mode Clock Controller

This block sits between a small processor's power-management register and the chip's clock tree. Software chooses one of five low-power modes with a 3-bit code, sets an enable bit and issues a one-cycle sleep strobe. The controller then drops the CPU clock. It keeps or stops the system clock for memory, DMA, events and interrupt logic, and the peripheral clock gates. It keeps or stops three oscillators: the main internal oscillator, the external crystal and the asynchronous counter oscillator. What it keeps depends on the chosen mode.

While asleep, the controller watches the wake sources that the mode allows. On a valid wake it turns the oscillators back on at once. If the oscillator that feeds the CPU was stopped, it holds the CPU, system and peripheral clocks off for a settle time that software programs. Outside the deep modes, each peripheral clock can be gated by its own stop bit.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: While and after reset, with all stop bits and oscillator requests low, the block is awake: `sleeping`=0, and CPU, system, main oscillator and every peripheral clock enable are 1. A reset that occurs during sleep returns the block to this awake state.
- R2: When `sleep_en`=1, `sleep_req`=1 and the code on `mode_sel` is valid, the outputs take the sleep values of that mode on the next clock edge, with `sleeping`=1 and `cpu_clk_en`=0.
- R3: A request is ignored and the block stays awake in two cases: the code is reserved (001, 100 or 101), or `sleep_en`=0.
- R4: Idle (code 000) stops only the CPU clock. The system clock, the peripheral gates and all three oscillators keep their awake values.
- R5: Power-down (code 010) drives every clock and oscillator enable to 0.
- R6: Power-save (code 011) equals power-down, except that `rtc_osc_en` follows `rtc_req`.
- R7: Standby (code 110) equals power-down, except that `xtal_osc_en` keeps its awake value `xtal_req | sysclk_xtal`.
- R8: Extended standby (code 111) keeps `main_osc_en`=1 and `rtc_osc_en`=`rtc_req`. It stops the crystal.
- R9: In idle, a wake comes from `irq_any`, `twi_match`, `usb_resume` or `pin_change`. In the four deeper modes only the last three wake the block, and `irq_any` has no effect.
- R10: On a wake that needs settling, the oscillators return to their awake values on the next edge. The CPU, system and peripheral clocks stay off, with `sleeping`=1, for `settle_len` cycles and are then released. A `settle_len` of 0 releases them at once.
- R11: Settling is skipped, and the block is fully awake on the edge after the wake, when the CPU clock's source oscillator was kept running. This applies to idle, to standby with `sysclk_xtal`=1, and to extended standby with `sysclk_xtal`=0.
- R12: If a wake source that is valid for the requested mode is high in the cycle of the sleep request, the entry is cancelled and the block stays awake.
- R13: While awake or in idle, `periph_clk_en[i]` equals `~periph_stop[i]`, one cycle after the stop bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_en | input | 1 | Sleep enable bit |
| mode_sel | input | 3 | Sleep mode code |
| sleep_req | input | 1 | One-cycle sleep request strobe |
| irq_any | input | 1 | Any enabled interrupt pending |
| twi_match | input | 1 | Two-wire bus address match |
| usb_resume | input | 1 | USB resume signalling |
| pin_change | input | 1 | Pin-change interrupt |
| settle_len | input | CNT_W | Oscillator settle cycles (0..15) |
| sysclk_xtal | input | 1 | CPU clock taken from crystal (1) or main oscillator (0) |
| xtal_req | input | 1 | Software keeps crystal on while awake |
| rtc_req | input | 1 | Software keeps counter oscillator on |
| periph_stop | input | N_PERIPH | Per-peripheral clock stop bits |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | N_PERIPH | Peripheral clock enables |
| sys_clk_en | output | 1 | SRAM/DMA/event/interrupt clock enable |
| main_osc_en | output | 1 | Main oscillator enable |
| xtal_osc_en | output | 1 | Crystal oscillator enable |
| rtc_osc_en | output | 1 | Asynchronous counter oscillator enable |
| sleeping | output | 1 | Asleep or settling |

## Verification
The bench holds `irq_any` high during deep sleep. A design that woke on it would go awake early. Requests are sent with reserved codes, with the enable bit clear, and with a wake source high in the same cycle; an incorrect design would enter sleep in each of these cases. Settle lengths of 0 and 15 are combined with every mode and both clock sources. Each settling cycle is checked, which exposes an off-by-one count, a settle wrongly skipped or wrongly applied, and clocks released before the oscillators come back. Stop bits are changed in idle and while awake to catch gates that ignore them or that lag by the wrong number of cycles.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam logic [2:0] CODE_IDLE  = 3'b000;
  localparam logic [2:0] CODE_PDOWN = 3'b010;
  localparam logic [2:0] CODE_PSAVE = 3'b011;
  localparam logic [2:0] CODE_STBY  = 3'b110;
  localparam logic [2:0] CODE_XSTBY = 3'b111;

  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_SETTLE} slp_state_e;

  typedef struct packed {
    logic valid;
    logic irq_wakes;
    logic keep_sys;
    logic keep_main;
    logic keep_xtal;
    logic keep_rtc;
  } mode_attr_t;
endpackage

// File: rtl/slp_mode_decode.sv
module slp_mode_decode
  import slp_pkg::*;
(
  input  logic [2:0] code,
  output mode_attr_t attr
);
  always_comb begin
    attr = '0;
    case (code)
      CODE_IDLE: begin
        attr.valid = 1'b1; attr.irq_wakes = 1'b1; attr.keep_sys = 1'b1;
        attr.keep_main = 1'b1; attr.keep_xtal = 1'b1; attr.keep_rtc = 1'b1;
      end
      CODE_PDOWN: attr.valid = 1'b1;
      CODE_PSAVE: begin attr.valid = 1'b1; attr.keep_rtc = 1'b1; end
      CODE_STBY:  begin attr.valid = 1'b1; attr.keep_xtal = 1'b1; end
      CODE_XSTBY: begin
        attr.valid = 1'b1; attr.keep_main = 1'b1; attr.keep_rtc = 1'b1;
      end
      default: attr = '0;
    endcase
  end
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_en,
  input  logic             sleep_req,
  input  mode_attr_t       req_attr,
  input  logic             irq_any,
  input  logic             twi_wake,
  input  logic             usb_wake,
  input  logic             pin_wake,
  input  logic [CNT_W-1:0] settle_len,
  input  logic             sysclk_xtal,
  output slp_state_e       state_d,
  output mode_attr_t       attr_d
);
  slp_state_e       state_q;
  mode_attr_t       attr_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             deep_wake, src_kept;

  assign deep_wake = twi_wake | usb_wake | pin_wake;

  always_comb begin
    state_d  = state_q;
    attr_d   = attr_q;
    cnt_d    = cnt_q;
    src_kept = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (sleep_req && sleep_en && req_attr.valid &&
            !(deep_wake || (req_attr.irq_wakes && irq_any))) begin
          state_d = ST_SLEEP;
          attr_d  = req_attr;
        end
      end
      ST_SLEEP: begin
        if (deep_wake || (attr_q.irq_wakes && irq_any)) begin
          src_kept = sysclk_xtal ? attr_q.keep_xtal : attr_q.keep_main;
          if (src_kept || settle_len == '0) begin
            state_d = ST_RUN;
          end else begin
            state_d = ST_SETTLE;
            cnt_d   = settle_len;
          end
        end
      end
      ST_SETTLE: begin
        if (cnt_q <= CNT_W'(1)) state_d = ST_RUN;
        else                    cnt_d   = cnt_q - CNT_W'(1);
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      attr_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      attr_q  <= attr_d;
      cnt_q   <= cnt_d;
    end
  end

  assert_entry_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && $past(state_q) == ST_RUN) |->
      $past(sleep_req && sleep_en && req_attr.valid));

  assert_reserved_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && !req_attr.valid) |=> state_q == ST_RUN);

  assert_deep_irq_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && !attr_q.irq_wakes && !deep_wake) |=> state_q == ST_SLEEP);

  assert_settle_exit_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETTLE) |=> (state_q == ST_SETTLE || state_q == ST_RUN));

  assert_cancel_entry_R12: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && deep_wake) |=> state_q == ST_RUN);
endmodule

// File: rtl/slp_clk_out.sv
module slp_clk_out
  import slp_pkg::*;
#(
  parameter int N_PERIPH = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  slp_state_e          state_d,
  input  logic                keep_sys,
  input  logic                keep_main,
  input  logic                keep_xtal,
  input  logic                keep_rtc,
  input  logic                xtal_req,
  input  logic                rtc_req,
  input  logic                sysclk_xtal,
  input  logic [N_PERIPH-1:0] periph_stop,
  output logic                cpu_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                sys_clk_en,
  output logic                main_osc_en,
  output logic                xtal_osc_en,
  output logic                rtc_osc_en,
  output logic                sleeping
);
  logic xtal_awake;
  logic cpu_n, sys_n, main_n, xtal_n, rtc_n, per_n, slp_n;

  assign xtal_awake = xtal_req | sysclk_xtal;

  always_comb begin
    cpu_n = 1'b1; sys_n = 1'b1; main_n = 1'b1;
    xtal_n = xtal_awake; rtc_n = rtc_req; per_n = 1'b1; slp_n = 1'b0;
    case (state_d)
      ST_SETTLE: begin
        cpu_n = 1'b0; sys_n = 1'b0; per_n = 1'b0; slp_n = 1'b1;
      end
      ST_SLEEP: begin
        cpu_n  = 1'b0;
        sys_n  = keep_sys;
        per_n  = keep_sys;
        main_n = keep_main;
        xtal_n = keep_xtal & xtal_awake;
        rtc_n  = keep_rtc & rtc_req;
        slp_n  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en  <= 1'b1;
      sys_clk_en  <= 1'b1;
      main_osc_en <= 1'b1;
      xtal_osc_en <= 1'b0;
      rtc_osc_en  <= 1'b0;
      sleeping    <= 1'b0;
    end else begin
      cpu_clk_en  <= cpu_n;
      sys_clk_en  <= sys_n;
      main_osc_en <= main_n;
      xtal_osc_en <= xtal_n;
      rtc_osc_en  <= rtc_n;
      sleeping    <= slp_n;
    end
  end

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_gate
    always_ff @(posedge clk) begin
      if (rst) periph_clk_en[i] <= 1'b1;
      else     periph_clk_en[i] <= per_n & ~periph_stop[i];
    end
  end

  assert_enter_cpu_off_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sleeping) |-> !cpu_clk_en);

  assert_release_all_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(sleeping) |-> (cpu_clk_en && sys_clk_en && main_osc_en));
endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
  import slp_pkg::*;
#(
  parameter int N_PERIPH = 8,
  parameter int CNT_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sleep_en,
  input  logic [2:0]          mode_sel,
  input  logic                sleep_req,
  input  logic                irq_any,
  input  logic                twi_match,
  input  logic                usb_resume,
  input  logic                pin_change,
  input  logic [CNT_W-1:0]    settle_len,
  input  logic                sysclk_xtal,
  input  logic                xtal_req,
  input  logic                rtc_req,
  input  logic [N_PERIPH-1:0] periph_stop,
  output logic                cpu_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                sys_clk_en,
  output logic                main_osc_en,
  output logic                xtal_osc_en,
  output logic                rtc_osc_en,
  output logic                sleeping
);
  mode_attr_t req_attr, attr_d;
  slp_state_e state_d;

  slp_mode_decode u_dec (.code(mode_sel), .attr(req_attr));

  slp_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk, .rst, .sleep_en, .sleep_req, .req_attr, .irq_any,
    .twi_wake(twi_match), .usb_wake(usb_resume), .pin_wake(pin_change),
    .settle_len, .sysclk_xtal, .state_d, .attr_d
  );

  slp_clk_out #(.N_PERIPH(N_PERIPH)) u_out (
    .clk, .rst, .state_d,
    .keep_sys(attr_d.keep_sys), .keep_main(attr_d.keep_main),
    .keep_xtal(attr_d.keep_xtal), .keep_rtc(attr_d.keep_rtc),
    .xtal_req, .rtc_req, .sysclk_xtal, .periph_stop,
    .cpu_clk_en, .periph_clk_en, .sys_clk_en, .main_osc_en,
    .xtal_osc_en, .rtc_osc_en, .sleeping
  );
endmodule

// File: tb/sim_sleep_clk_ctrl.sv
`timescale 1ns/1ps
module sim_sleep_clk_ctrl;
  localparam int NP = 8;
  localparam int W  = 6 + NP;

  logic clk = 1'b0, rst = 1'b1;
  logic sleep_en = 0, sleep_req = 0, irq_any = 0, twi_match = 0, usb_resume = 0, pin_change = 0;
  logic [2:0] mode_sel = 0;
  logic [3:0] settle_len = 0;
  logic sysclk_xtal = 0, xtal_req = 0, rtc_req = 0;
  logic [NP-1:0] periph_stop = '0;
  logic cpu_clk_en, sys_clk_en, main_osc_en, xtal_osc_en, rtc_osc_en, sleeping;
  logic [NP-1:0] periph_clk_en;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sleep_clk_ctrl #(.N_PERIPH(NP), .CNT_W(4)) u0 (.*);

  // kind: 0 awake, 1 asleep in mode m, 2 settling
  function automatic logic [W-1:0] expv(int kind, logic [2:0] m);
    logic sl, cpu, sys, mo, xo, ro; logic [NP-1:0] pe; logic xa;
    xa = xtal_req | sysclk_xtal;
    sl = 1; cpu = 0; sys = 0; mo = 0; xo = 0; ro = 0; pe = '0;
    if (kind == 0) begin
      sl = 0; cpu = 1; sys = 1; mo = 1; xo = xa; ro = rtc_req; pe = ~periph_stop;
    end else if (kind == 2) begin
      mo = 1; xo = xa; ro = rtc_req;
    end else begin
      case (m)
        3'b000: begin sys = 1; mo = 1; xo = xa; ro = rtc_req; pe = ~periph_stop; end
        3'b011: ro = rtc_req;
        3'b110: xo = xa;
        3'b111: begin mo = 1; ro = rtc_req; end
        default: ;
      endcase
    end
    return {sl, cpu, sys, mo, xo, ro, pe};
  endfunction

  function automatic bit is_valid(logic [2:0] m);
    return m == 3'b000 || m == 3'b010 || m == 3'b011 || m == 3'b110 || m == 3'b111;
  endfunction

  function automatic int settle_cycles(logic [2:0] m);
    if (m == 3'b000) return 0;
    if (m == 3'b110 && sysclk_xtal) return 0;
    if (m == 3'b111 && !sysclk_xtal) return 0;
    return int'(settle_len);
  endfunction

  task automatic chk(string req, logic [W-1:0] e);
    logic [W-1:0] a;
    a = {sleeping, cpu_clk_en, sys_clk_en, main_osc_en, xtal_osc_en, rtc_osc_en, periph_clk_en};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, a, e, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_wake(int src);
    twi_match = (src == 0); usb_resume = (src == 1); pin_change = (src == 2); irq_any = (src == 3);
    step();
    twi_match = 0; usb_resume = 0; pin_change = 0; irq_any = 0;
  endtask

  // request sleep; cancel_src >= 0 raises that wake source in the same cycle
  task automatic request(logic [2:0] m, logic en, int cancel_src);
    mode_sel = m; sleep_en = en; sleep_req = 1;
    if (cancel_src >= 0) pulse_wake(cancel_src); else step();
    sleep_req = 0;
  endtask

  task automatic wake_and_check(logic [2:0] m, int src, string req);
    int n;
    n = settle_cycles(m);
    pulse_wake(src);
    for (int i = 0; i < n; i++) begin
      chk({req, " settle"}, expv(2, m));
      step();
    end
    chk({req, " awake"}, expv(0, m));
  endtask

  initial begin
    logic [2:0] codes [5] = '{3'b000, 3'b010, 3'b011, 3'b110, 3'b111};
    logic [2:0] rsv [3] = '{3'b001, 3'b100, 3'b101};
    void'($urandom(32'h5EED_0042));
    step(); step();
    chk("R1 during reset", expv(0, 0));
    rst = 0; step();
    chk("R1 after reset", expv(0, 0));

    // R3 reserved codes and disabled sleep
    for (int i = 0; i < 3; i++) begin
      request(rsv[i], 1, -1);
      chk("R3 reserved code", expv(0, 0));
    end
    request(3'b010, 0, -1);
    chk("R3 sleep_en low", expv(0, 0));

    // R4 idle with stop-bit change (R13), irq wake
    periph_stop = 8'hA5; step();
    chk("R13 awake stop bits", expv(0, 0));
    request(3'b000, 1, -1);
    chk("R4 idle", expv(1, 3'b000));
    periph_stop = 8'h3C; step();
    chk("R13 idle stop bits", expv(1, 3'b000));
    wake_and_check(3'b000, 3, "R9 idle irq R11");
    periph_stop = '0; step();

    // R5 power-down, irq ignored, settle 15
    settle_len = 4'd15; sysclk_xtal = 0;
    request(3'b010, 1, -1);
    chk("R5 power-down", expv(1, 3'b010));
    irq_any = 1; step(); step(); irq_any = 0;
    chk("R9 irq ignored deep", expv(1, 3'b010));
    wake_and_check(3'b010, 1, "R10 settle 15");

    // R6/R7/R8 with oscillator requests
    xtal_req = 1; rtc_req = 1; settle_len = 4'd0;
    request(3'b011, 1, -1);
    chk("R6 power-save", expv(1, 3'b011));
    wake_and_check(3'b011, 2, "R10 settle 0");
    sysclk_xtal = 1; settle_len = 4'd5;
    request(3'b110, 1, -1);
    chk("R7 standby", expv(1, 3'b110));
    wake_and_check(3'b110, 0, "R11 standby xtal");
    sysclk_xtal = 0;
    request(3'b111, 1, -1);
    chk("R8 ext standby", expv(1, 3'b111));
    wake_and_check(3'b111, 0, "R11 ext standby main");

    // R12 cancel
    request(3'b010, 1, 2);
    chk("R12 cancel deep", expv(0, 0));
    request(3'b000, 1, 3);
    chk("R12 cancel idle irq", expv(0, 0));

    // R1 reset while asleep
    request(3'b010, 1, -1);
    rst = 1; step(); rst = 0; step();
    chk("R1 reset wakes", expv(0, 0));

    // random mix
    for (int it = 0; it < 300; it++) begin
      logic [2:0] m; logic en; int cancel; int src;
      m = ($urandom % 5 == 0) ? rsv[$urandom % 3] : codes[$urandom % 5];
      en = ($urandom % 10) != 0;
      cancel = ($urandom % 7 == 0) ? int'($urandom % 3) : -1;
      settle_len = 4'($urandom); sysclk_xtal = 1'($urandom);
      xtal_req = 1'($urandom); rtc_req = 1'($urandom); periph_stop = NP'($urandom);
      step();
      request(m, en, cancel);
      if (en && is_valid(m) && cancel < 0) begin
        chk("R2 random entry", expv(1, m));
        for (int k = 0; k < int'($urandom % 4); k++) begin
          if (m != 3'b000) irq_any = 1;
          step();
          chk("R9 random hold", expv(1, m));
        end
        irq_any = 0;
        src = (m == 3'b000) ? int'($urandom % 4) : int'($urandom % 3);
        wake_and_check(m, src, "R10 R11 random wake");
      end else begin
        chk("R3 R12 random no entry", expv(0, 0));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule